// File: doc/BRIEF.md
# Strobed SRAM Cycle Sequencer

This block sits between a simple host request port and a 1-bit-wide static RAM that captures its address when its enable strobe falls. It has one data pin shared by input and output. For each accepted request it produces an active-low enable (E), a write strobe (W) and a chip select (S) waveform, counted in system clocks. Every timing minimum of the RAM is a parameter, given as a number of clocks rounded up from the nanosecond figure.

Three operations are supported: read, write, and read-modify-write. A read-modify-write returns the old bit and stores a new one inside a single enable-low window. The host raises `req_i` with the operation flags, address and write bit for one clock while `busy_o` is low. It then waits for `busy_o` to fall. Read results arrive as a one-clock `rvalid_o` pulse carrying the sampled bit.

The controller holds the address from one clock before E falls until the recovery period ends. It delays driving the shared data pin until the RAM output has had time to turn off after W falls. It keeps the written bit stable for the setup window before W rises.

Top module: `sram_strobe_seq`

## Requirements
- R1: While reset is held and right after it, `busy_o` and `rvalid_o` are 0, `mem_dq_oe_o` is 0, and `mem_e_n_o`, `mem_w_n_o` and `mem_s_n_o` are 1.
- R2: A request seen while `busy_o` is 0 is accepted: `busy_o` is 1 from the next clock on. Requests seen while `busy_o` is 1 are ignored; they add no enable cycle and change no memory contents.
- R3: The address captured at acceptance is on `mem_addr_o` for one clock before E falls. It stays unchanged until `busy_o` falls, whatever `addr_i` does in the meantime.
- R4: The enable-low window lasts LR = max(EL, ACC+1, AH) clocks for a read and LW = max(EL, AH, WP, OZ+DS) clocks for a write. For a read-modify-write it lasts LM = max(EL, AH, ACC+1+max(WP, OZ+DS)) clocks. `mem_s_n_o` always equals `mem_e_n_o`.
- R5: After E rises, `busy_o` stays 1 for max(EH, CYC-L) clocks, where L is the window length from R4. `busy_o` is therefore 1 for 1+L+max(EH, CYC-L) clocks in total. Successive E falling edges are at least CYC clocks apart.
- R6: A read samples `mem_dq_i` at the end of window clock ACC, counting the first low clock as 0, with W high. The next clock carries a single one-clock `rvalid_o` pulse with that bit on `rdata_o`.
- R7: In a write, W falls together with E, stays low until E rises, and no `rvalid_o` pulse occurs.
- R8: `mem_dq_oe_o` rises exactly OZ clocks after W falls. It stays high until W rises, which gives at least DS clocks of driven data before W rises. It is never 1 while W is high.
- R9: In a read-modify-write, W stays high through the sample of R6 and falls at window clock ACC+1. The RAM afterwards holds the new bit, and `rdata_o` returns the old one.
- R10: Every W low pulse lasts at least WP clocks, and W is never low while E is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| rmw_i | input | 1 | 1 = read-modify-write (overrides we_i) |
| addr_i | input | AW | Request address |
| wdata_i | input | 1 | Bit to write |
| busy_o | output | 1 | Cycle in progress |
| rvalid_o | output | 1 | One-clock read-data-valid pulse |
| rdata_o | output | 1 | Sampled read bit |
| mem_addr_o | output | AW | RAM address |
| mem_e_n_o | output | 1 | RAM enable, active low |
| mem_w_n_o | output | 1 | RAM write strobe, active low |
| mem_s_n_o | output | 1 | RAM select, active low (both selects) |
| mem_dq_o | output | 1 | Bit driven to the shared data pin |
| mem_dq_oe_o | output | 1 | Drive enable for the shared data pin |
| mem_dq_i | input | 1 | Bit sampled from the shared data pin |

## Verification
A wrong window length or recovery count shows at the ports within the same operation. The length of E low, the position of the W edge, or the busy length is off by the error, and a bench can measure each of these to the clock. A sampling counter that is off by even one clock reads the RAM before its data is valid, so a bad bit appears on `rdata_o` one clock after the sample. A wrong drive delay either overlaps the RAM output or shortens the data setup, and a wrong write-path state leaves a wrong bit in the RAM. That wrong bit surfaces on the next read of the same address.

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq #(
  parameter int AW      = 10,
  parameter int AH_CYC  = 4,
  parameter int EL_CYC  = 18,
  parameter int EH_CYC  = 10,
  parameter int CYC_CYC = 28,
  parameter int ACC_CYC = 18,
  parameter int WP_CYC  = 10,
  parameter int DS_CYC  = 8,
  parameter int OZ_CYC  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          rmw_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wdata_i,
  output logic          busy_o,
  output logic          rvalid_o,
  output logic          rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_e_n_o,
  output logic          mem_w_n_o,
  output logic          mem_s_n_o,
  output logic          mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic          mem_dq_i
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WR_SPAN = mx(WP_CYC, OZ_CYC + DS_CYC);
  localparam int LEN_RD  = mx(mx(EL_CYC, AH_CYC), ACC_CYC + 1);
  localparam int LEN_WR  = mx(mx(EL_CYC, AH_CYC), WR_SPAN);
  localparam int LEN_RMW = mx(mx(EL_CYC, AH_CYC), ACC_CYC + 1 + WR_SPAN);
  localparam int REC_RD  = mx(EH_CYC, CYC_CYC - LEN_RD);
  localparam int REC_WR  = mx(EH_CYC, CYC_CYC - LEN_WR);
  localparam int REC_RMW = mx(EH_CYC, CYC_CYC - LEN_RMW);
  localparam int TOP     = mx(mx(LEN_RMW, LEN_WR), mx(mx(REC_RD, REC_WR), REC_RMW)) + OZ_CYC;
  localparam int CW      = $clog2(TOP + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_LOW, S_REC} st_t;

  st_t           st;
  logic [CW-1:0] cnt, len, rec, wbeg;
  logic          do_rd, do_wr, wd_q, rv_q, rd_q;
  logic [AW-1:0] addr_q;

  wire in_low = (st == S_LOW);
  wire w_act  = in_low && do_wr && (cnt >= wbeg);
  wire sample = in_low && do_rd && (cnt == CW'(ACC_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; len <= '0; rec <= '0; wbeg <= '0;
      do_rd <= 1'b0; do_wr <= 1'b0; wd_q <= 1'b0; addr_q <= '0;
      rv_q <= 1'b0; rd_q <= 1'b0;
    end else begin
      rv_q <= sample;
      if (sample) rd_q <= mem_dq_i;
      case (st)
        S_IDLE: if (req_i) begin
          st     <= S_SETUP;
          addr_q <= addr_i;
          wd_q   <= wdata_i;
          do_rd  <= rmw_i | ~we_i;
          do_wr  <= rmw_i | we_i;
          len    <= rmw_i ? CW'(LEN_RMW) : (we_i ? CW'(LEN_WR) : CW'(LEN_RD));
          rec    <= rmw_i ? CW'(REC_RMW) : (we_i ? CW'(REC_WR) : CW'(REC_RD));
          wbeg   <= rmw_i ? CW'(ACC_CYC + 1) : '0;
        end
        S_SETUP: begin
          st  <= S_LOW;
          cnt <= '0;
        end
        S_LOW: begin
          if (cnt == len - 1'b1) begin
            st  <= S_REC;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == rec - 1'b1) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign busy_o      = (st != S_IDLE);
  assign rvalid_o    = rv_q;
  assign rdata_o     = rd_q;
  assign mem_addr_o  = addr_q;
  assign mem_e_n_o   = ~in_low;
  assign mem_s_n_o   = ~in_low;
  assign mem_w_n_o   = ~w_act;
  assign mem_dq_o    = wd_q;
  assign mem_dq_oe_o = w_act && (cnt >= wbeg + CW'(OZ_CYC));

endmodule

// File: rtl/sram_strobe_seq_chk.sv
module sram_strobe_seq_chk #(
  parameter int AW     = 10,
  parameter int WP_CYC = 10,
  parameter int OZ_CYC = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          rvalid_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_e_n_o,
  input logic          mem_w_n_o,
  input logic          mem_s_n_o,
  input logic          mem_dq_oe_o
);

  logic [15:0] wlow;
  always_ff @(posedge clk) begin
    if (!rst_n) wlow <= '0;
    else if (mem_w_n_o) wlow <= '0;
    else if (wlow != 16'hFFFF) wlow <= wlow + 1'b1;
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(mem_addr_o));

  // R4
  sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_s_n_o == mem_e_n_o);

  // R6
  rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |=> !rvalid_o);

  // R8
  drive_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe_o |-> (!mem_w_n_o && wlow >= OZ_CYC));

  // R10
  w_inside_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_w_n_o |-> !mem_e_n_o);

  // R10
  w_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_w_n_o) |-> wlow >= WP_CYC);

endmodule

bind sram_strobe_seq sram_strobe_seq_chk #(.AW(AW), .WP_CYC(WP_CYC), .OZ_CYC(OZ_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .rvalid_o(rvalid_o),
  .mem_addr_o(mem_addr_o), .mem_e_n_o(mem_e_n_o), .mem_w_n_o(mem_w_n_o),
  .mem_s_n_o(mem_s_n_o), .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/sram_strobe_seq_test.sv
module sram_strobe_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, AH = 2, EL = 4, EH = 2, CYC = 9, ACC = 3, WP = 3, DS = 2, OZ = 2;

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int win_len(input int k);
    if (k == 0) return mx(mx(EL, ACC + 1), AH);
    if (k == 1) return mx(mx(EL, AH), mx(WP, OZ + DS));
    return mx(mx(EL, AH), ACC + 1 + mx(WP, OZ + DS));
  endfunction

  logic clk = 0, rst_n = 0, req = 0, we = 0, rmw = 0, wd = 0;
  logic [AW-1:0] addr = '0;
  logic busy, rvalid, rdata, e_n, w_n, s_n, dq_o, dq_oe, dq_i;
  logic [AW-1:0] maddr;

  sram_strobe_seq #(.AW(AW), .AH_CYC(AH), .EL_CYC(EL), .EH_CYC(EH), .CYC_CYC(CYC),
    .ACC_CYC(ACC), .WP_CYC(WP), .DS_CYC(DS), .OZ_CYC(OZ)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .rmw_i(rmw), .addr_i(addr),
    .wdata_i(wd), .busy_o(busy), .rvalid_o(rvalid), .rdata_o(rdata),
    .mem_addr_o(maddr), .mem_e_n_o(e_n), .mem_w_n_o(w_n), .mem_s_n_o(s_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  bit ram [16];
  bit shadow [16];
  int ecnt = 0;
  always @(posedge clk) ecnt <= e_n ? 0 : ecnt + 1;
  assign dq_i = (!e_n && w_n && ecnt >= ACC) ? ram[maddr] : ~ram[maddr];

  int cur_kind = 0, cur_addr = 0, efalls = 0, rvc = 0, rvd = 0;
  int cyc = 0, last_fall = -1, elen = 0, wf = -1, dst = -1, dc = 0;
  bit sflag = 0, aflag = 0, oeflag = 0, pe = 1, pw = 1, pend = 0;
  logic [AW-1:0] pa = '0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (s_n != e_n) sflag = 1;
    if (dq_oe && w_n) oeflag = 1;
    if (!w_n && e_n) oeflag = 1;
    if (rvalid) begin rvc++; rvd = rdata; end
    if (!e_n) begin
      if (pe) begin
        efalls++;
        if (last_fall >= 0) chk(cyc - last_fall >= CYC, "R5 fall spacing", cyc - last_fall, CYC);
        last_fall = cyc; elen = 0; wf = -1; dst = -1; dc = 0;
        if (int'(maddr) != cur_addr) aflag = 1;
      end else if (maddr != pa) aflag = 1;
      if (!w_n && wf < 0) wf = elen;
      if (dq_oe && dst < 0) dst = elen;
      if (dq_oe) begin dc++; pend = dq_o; end
      elen++;
    end else if (!pe) begin
      chk(elen == win_len(cur_kind), "R4 window", elen, win_len(cur_kind));
      if (cur_kind == 0) chk(wf < 0, "R6 no W in read", wf, -1);
      else begin
        if (cur_kind == 2) chk(wf == ACC + 1, "R9 W fall", wf, ACC + 1);
        else chk(wf == 0, "R7 W fall", wf, 0);
        chk(dst - wf == OZ, "R8 drive delay", dst - wf, OZ);
        chk(dc >= DS, "R8 setup", dc, DS);
        chk(elen - wf >= WP, "R10 W width", elen - wf, WP);
      end
    end
    if (!pw && w_n) ram[maddr] = pend;
    pe = e_n; pw = w_n; pa = maddr;
  end

  task automatic op(input int kind, input int a, input bit d);
    int n;
    int l;
    cur_kind = kind; cur_addr = a; efalls = 0; rvc = 0;
    sflag = 0; aflag = 0; oeflag = 0;
    l = win_len(kind);
    @(negedge clk);
    req = 1; we = (kind == 1); rmw = (kind == 2); addr = AW'(a); wd = d;
    @(negedge clk);
    req = 0; addr = ~AW'(a);
    chk(busy, "R2 accept", busy, 1);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 3) begin req = 1; we = 1; rmw = 0; addr = AW'(a ^ 1); wd = ~d; end
      else req = 0;
      @(negedge clk);
    end
    req = 0;
    chk(n == 1 + l + mx(EH, CYC - l), "R5 busy length", n, 1 + l + mx(EH, CYC - l));
    chk(efalls == 1, "R2 ignored request", efalls, 1);
    chk(!aflag, "R3 address", aflag, 0);
    chk(!sflag, "R4 select", sflag, 0);
    chk(!oeflag, "R8 R10 drive/W", oeflag, 0);
    if (kind == 1) chk(rvc == 0, "R7 no rvalid", rvc, 0);
    else begin
      chk(rvc == 1, "R6 rvalid pulse", rvc, 1);
      chk(rvd == int'(shadow[a]), kind == 2 ? "R9 old bit" : "R6 read bit", rvd, shadow[a]);
    end
    if (kind != 0) shadow[a] = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rvalid && !dq_oe, "R1 reset outputs", {busy, rvalid, dq_oe}, 0);
    chk(e_n && w_n && s_n, "R1 reset strobes", {e_n, w_n, s_n}, 7);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && e_n, "R1 after reset", busy, 0);
    for (int a = 0; a < 16; a++) op(1, a, a[0] ^ a[3]);
    for (int a = 0; a < 16; a++) op(0, a, 0);
    for (int a = 0; a < 16; a++) op(2, a, ~shadow[a]);
    for (int a = 0; a < 16; a++) op(0, a, 0);
    for (int a = 15; a >= 0; a--) op(1, a, a[1]);
    for (int a = 0; a < 16; a++) op(2, a, a[2]);
    for (int a = 0; a < 16; a++) op(0, a, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule